// File: doc/BRIEF.md
# SPI NOR Flash Transaction Engine

This block acts as the controller side of a serial NOR flash link and carries out one transaction per request. A transaction always begins with an 8-bit opcode. An optional 24-bit address may follow, then optional dummy clocks, then an optional data phase. The host supplies the opcode, address, an address flag, the direction and a byte length in a single-cycle request. Write bytes enter through a small TX FIFO. Read bytes leave through a small RX FIFO with the head word always visible.

The opcode selects the transfer mode. Three opcodes receive special treatment, and each is a parameter. The fast read (default 0xBB) reads on two lanes after dummy clocks. The page program (default 0xA2) writes on two lanes. The discovery-table read (default 0x5A) reads on one lane after a one-byte wait. Every other opcode is command-only when the length is zero. Otherwise it is write-only or read-only according to the request. SCLK idles low, and each bit is launched on a falling edge and captured on a rising edge. When the TX FIFO is empty or the RX FIFO is full at a byte boundary, the serial clock pauses until the FIFO can continue.

Top module: `sfx_engine`

## Requirements
- R1: After a request is accepted, the first 8 SCLK rising edges carry the opcode MSB first on `spi_io_out[0]`, with `spi_io_oe` = 2'b01.
- R2: If the request sets `req_addr_en`, the opcode is followed by the 24-bit address, MSB first. If the flag is clear and the opcode is not special, no address is sent.
- R3: A zero-length request for a non-special opcode sends only the opcode and any address. Chip select then rises with no further SCLK edges.
- R4: A request of N bytes moves N bytes. A request of more than 512 bytes moves exactly 512.
- R5: The fast-read opcode always sends the address. The address and data use two lanes, with `io[1]` carrying the higher bit of each pair. Three SCLK cycles with `spi_io_oe` = 2'b00 come before the data.
- R6: The discovery-read opcode always sends the address on one lane. Eight dummy SCLK cycles with outputs disabled follow, and then data is read from `spi_io_in[1]`.
- R7: The page-program opcode always sends the address. The address and write data go out on two lanes, with `spi_io_oe` = 2'b11.
- R8: A fast-read or page-program request of length zero raises `done` in the cycle after acceptance, and chip select never falls.
- R9: Write bytes leave in TX FIFO order, MSB first. On one lane they appear on `spi_io_out[0]`. If the FIFO is empty before a byte, SCLK pauses and no byte is lost or repeated.
- R10: Read bytes are sampled MSB first on rising SCLK edges and pushed into the RX FIFO in order. A full RX FIFO pauses SCLK before the next byte.
- R11: `busy` is high from acceptance until `done`. Chip select stays low for the whole transaction, and SCLK is low whenever chip select is high. Requests made while `busy` is high are ignored.
- R12: `done` is a one-cycle pulse in the cycle where chip select returns high.
- R13: After reset, `spi_cs_n`=1, `spi_sclk`=0, `busy`=0, `done`=0, `spi_io_oe`=0, `tx_free`=TX depth and `rx_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_opcode | input | 8 | Command opcode |
| req_addr | input | 24 | Flash address |
| req_addr_en | input | 1 | Send the address phase |
| req_write | input | 1 | 1 = write data, 0 = read data |
| req_len | input | 10 | Data byte count, capped at 512 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_push | input | 1 | Write a byte into the TX FIFO |
| tx_data | input | 8 | TX byte |
| tx_free | output | 3 | Free TX FIFO slots |
| rx_pop | input | 1 | Remove the RX FIFO head |
| rx_data | output | 8 | RX FIFO head byte |
| rx_empty | output | 1 | RX FIFO holds no byte |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_out | output | 2 | Serial data out, lanes 1..0 |
| spi_io_oe | output | 2 | Per-lane output enable |
| spi_io_in | input | 2 | Serial data in, lanes 1..0 |

## Verification
The bench aims at the transitions between phases. These include a forced address on the special opcodes when the address flag is clear, the dummy windows of three and eight cycles, and the switch from one lane to two. A design that gets any of these wrong shifts every later bit, and the flash model reports a bad address or bad data bytes. Paced TX feeding and delayed RX draining force the SCLK pause at byte boundaries; a design without that pause drops or duplicates bytes. Zero-length special requests, a 600-byte request and a request made while busy cover the drop, the cap and the ignore rule. Getting any of these wrong produces bus activity, a byte count or a transaction that the scoreboard does not expect.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_TAIL} phase_e;
  typedef enum logic [1:0] {XM_CMD_ONLY, XM_WRITE, XM_READ, XM_DUMMY_READ} xmode_e;
  typedef struct packed {
    logic       drop;
    xmode_e     mode;
    logic       use_addr;
    logic       dual;
    logic [3:0] dummy;
  } xplan_t;
endpackage

// File: rtl/sfx_decode.sv
module sfx_decode
  import sfx_pkg::*;
#(
  parameter logic [7:0] OPC_FREAD   = 8'hBB,
  parameter logic [7:0] OPC_PROG    = 8'hA2,
  parameter logic [7:0] OPC_DISC    = 8'h5A,
  parameter int         FREAD_DUMMY = 3,
  parameter int         DISC_DUMMY  = 8
) (
  input  logic [7:0] opcode,
  input  logic       addr_en,
  input  logic       is_write,
  input  logic       len_zero,
  output xplan_t     plan
);
  always_comb begin
    plan.drop     = 1'b0;
    plan.use_addr = addr_en;
    plan.dual     = 1'b0;
    plan.dummy    = '0;
    if (len_zero)      plan.mode = XM_CMD_ONLY;
    else if (is_write) plan.mode = XM_WRITE;
    else               plan.mode = XM_READ;

    if (opcode == OPC_FREAD) begin
      plan.use_addr = 1'b1;
      plan.dual     = 1'b1;
      plan.dummy    = 4'(FREAD_DUMMY);
      plan.mode     = XM_DUMMY_READ;
      plan.drop     = len_zero;
    end else if (opcode == OPC_PROG) begin
      plan.use_addr = 1'b1;
      plan.dual     = 1'b1;
      plan.mode     = XM_WRITE;
      plan.drop     = len_zero;
    end else if (opcode == OPC_DISC) begin
      plan.use_addr = 1'b1;
      if (!len_zero) begin
        plan.mode  = XM_DUMMY_READ;
        plan.dummy = 4'(DISC_DUMMY);
      end
    end
  end
endmodule

// File: rtl/sfx_fifo.sv
module sfx_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  assign pop_data = mem[rd_q];
  assign count    = cnt_q;
endmodule

// File: rtl/sfx_tick.sv
module sfx_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_full
      assign tick = run;
    end else begin : g_div
      localparam int HW = $clog2(DIV);
      logic [HW-1:0] h_q, h_d;
      always_comb begin
        if (!run)                     h_d = '0;
        else if (h_q == HW'(DIV - 1)) h_d = '0;
        else                          h_d = h_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
      end
      assign tick = run && (h_q == HW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/sfx_engine.sv
module sfx_engine
  import sfx_pkg::*;
#(
  parameter int         DIV         = 2,
  parameter int         TX_DEPTH    = 4,
  parameter int         RX_DEPTH    = 4,
  parameter int         MAX_BYTES   = 512,
  parameter int         ADDR_W      = 24,
  parameter logic [7:0] OPC_FREAD   = 8'hBB,
  parameter logic [7:0] OPC_PROG    = 8'hA2,
  parameter logic [7:0] OPC_DISC    = 8'h5A,
  parameter int         FREAD_DUMMY = 3,
  parameter int         DISC_DUMMY  = 8,
  localparam int        LEN_W       = $clog2(MAX_BYTES + 1),
  localparam int        TXC_W       = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_opcode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_addr_en,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  input  logic              tx_push,
  input  logic [7:0]        tx_data,
  output logic [TXC_W-1:0]  tx_free,
  input  logic              rx_pop,
  output logic [7:0]        rx_data,
  output logic              rx_empty,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic [1:0]        spi_io_out,
  output logic [1:0]        spi_io_oe,
  input  logic [1:0]        spi_io_in
);
  localparam int CNT_W = $clog2(MAX_BYTES);
  localparam int RXC_W = $clog2(RX_DEPTH + 1);
  localparam int SH_W  = ADDR_W;
  localparam int CYC_W = $clog2(SH_W + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  xplan_t plan;
  sfx_decode #(
    .OPC_FREAD(OPC_FREAD), .OPC_PROG(OPC_PROG), .OPC_DISC(OPC_DISC),
    .FREAD_DUMMY(FREAD_DUMMY), .DISC_DUMMY(DISC_DUMMY)
  ) u_dec (
    .opcode(req_opcode), .addr_en(req_addr_en), .is_write(req_write),
    .len_zero(req_len == '0), .plan(plan)
  );

  phase_e            ph_q, ph_d, nxt;
  xmode_e            mode_q, mode_d;
  logic              sclk_q, sclk_d, csn_q, csn_d, done_q, done_d;
  logic              dual_q, dual_d, uaddr_q, uaddr_d, loaded_q, loaded_d;
  logic [3:0]        dum_q, dum_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [6:0]        rxs_q, rxs_d;

  logic             tick, rise, fall, run, lane2, rd_mode, bit_phase;
  logic             tx_pop, rx_push;
  logic [7:0]       tx_head, rx_shifted;
  logic [TXC_W-1:0] tx_count;
  logic [RXC_W-1:0] rx_count;
  phase_e           after_addr;
  logic [CYC_W-1:0] byte_cyc;

  sfx_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_ns), .push(tx_push), .push_data(tx_data),
    .pop(tx_pop), .pop_data(tx_head), .count(tx_count)
  );
  sfx_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_ns), .push(rx_push), .push_data(rx_shifted),
    .pop(rx_pop), .pop_data(rx_data), .count(rx_count)
  );

  assign bit_phase = (ph_q inside {PH_CMD, PH_ADDR, PH_DUMMY}) || (ph_q == PH_DATA && loaded_q);
  assign run       = bit_phase || (ph_q == PH_TAIL);

  sfx_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_ns), .run(run), .tick(tick));

  assign rise       = bit_phase && tick && !sclk_q;
  assign fall       = bit_phase && tick && sclk_q;
  assign lane2      = dual_q && (ph_q == PH_ADDR || ph_q == PH_DATA);
  assign rd_mode    = (mode_q == XM_READ) || (mode_q == XM_DUMMY_READ);
  assign rx_shifted = lane2 ? {rxs_q[5:0], spi_io_in[1:0]} : {rxs_q[6:0], spi_io_in[1]};
  assign byte_cyc   = dual_q ? CYC_W'(4) : CYC_W'(8);
  assign after_addr = (dum_q != '0) ? PH_DUMMY : ((mode_q == XM_CMD_ONLY) ? PH_TAIL : PH_DATA);

  always_comb begin
    ph_d     = ph_q;     mode_d = mode_q;  sclk_d = sclk_q;   csn_d  = csn_q;
    dual_d   = dual_q;   uaddr_d = uaddr_q; loaded_d = loaded_q;
    dum_d    = dum_q;    sh_d   = sh_q;    addr_d = addr_q;   cyc_d  = cyc_q;
    rem_d    = rem_q;    rxs_d  = rxs_q;
    done_d   = 1'b0;     tx_pop = 1'b0;    rx_push = 1'b0;    nxt    = ph_q;

    case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (plan.drop) begin
            done_d = 1'b1;
          end else begin
            ph_d    = PH_CMD;
            csn_d   = 1'b0;
            sclk_d  = 1'b0;
            sh_d    = {req_opcode, {(SH_W - 8){1'b0}}};
            cyc_d   = CYC_W'(8);
            mode_d  = plan.mode;
            dual_d  = plan.dual;
            uaddr_d = plan.use_addr;
            dum_d   = plan.dummy;
            addr_d  = req_addr;
            rem_d   = (req_len > LEN_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES - 1)
                                                    : CNT_W'(req_len - 1'b1);
          end
        end
      end
      PH_TAIL: begin
        if (tick) begin
          csn_d  = 1'b1;
          done_d = 1'b1;
          ph_d   = PH_IDLE;
        end
      end
      PH_DATA: begin
        if (!loaded_q) begin
          if (mode_q == XM_WRITE) begin
            if (tx_count != '0) begin
              tx_pop   = 1'b1;
              sh_d     = {tx_head, {(SH_W - 8){1'b0}}};
              loaded_d = 1'b1;
              cyc_d    = byte_cyc;
            end
          end else if (rx_count != RXC_W'(RX_DEPTH)) begin
            loaded_d = 1'b1;
            cyc_d    = byte_cyc;
          end
        end
      end
      default: ;
    endcase

    if (rise) begin
      sclk_d = 1'b1;
      if (ph_q == PH_DATA && rd_mode) begin
        rxs_d = rx_shifted[6:0];
        if (cyc_q == CYC_W'(1)) rx_push = 1'b1;
      end
    end else if (fall) begin
      sclk_d = 1'b0;
      sh_d   = lane2 ? (sh_q << 2) : (sh_q << 1);
      cyc_d  = cyc_q - 1'b1;
      if (cyc_q == CYC_W'(1)) begin
        case (ph_q)
          PH_CMD:   nxt = uaddr_q ? PH_ADDR : after_addr;
          PH_ADDR:  nxt = after_addr;
          PH_DUMMY: nxt = PH_DATA;
          default:  nxt = (rem_q == '0) ? PH_TAIL : PH_DATA;
        endcase
        if (ph_q == PH_DATA && rem_q != '0) rem_d = rem_q - 1'b1;
        ph_d = nxt;
        case (nxt)
          PH_ADDR: begin
            sh_d  = addr_q;
            cyc_d = dual_q ? CYC_W'(ADDR_W / 2) : CYC_W'(ADDR_W);
          end
          PH_DUMMY: cyc_d = CYC_W'(dum_q);
          PH_DATA:  loaded_d = 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ph_q <= PH_IDLE;  mode_q <= XM_CMD_ONLY; sclk_q <= 1'b0; csn_q <= 1'b1;
      done_q <= 1'b0;   dual_q <= 1'b0; uaddr_q <= 1'b0; loaded_q <= 1'b0;
      dum_q <= '0;      sh_q <= '0;     addr_q <= '0;    cyc_q <= '0;
      rem_q <= '0;      rxs_q <= '0;
    end else begin
      ph_q <= ph_d;     mode_q <= mode_d; sclk_q <= sclk_d; csn_q <= csn_d;
      done_q <= done_d; dual_q <= dual_d; uaddr_q <= uaddr_d; loaded_q <= loaded_d;
      dum_q <= dum_d;   sh_q <= sh_d;     addr_q <= addr_d;   cyc_q <= cyc_d;
      rem_q <= rem_d;   rxs_q <= rxs_d;
    end
  end

  always_comb begin
    spi_io_oe = 2'b00;
    if (ph_q == PH_CMD)                                  spi_io_oe = 2'b01;
    else if (ph_q == PH_ADDR)                            spi_io_oe = dual_q ? 2'b11 : 2'b01;
    else if (ph_q == PH_DATA && mode_q == XM_WRITE)      spi_io_oe = dual_q ? 2'b11 : 2'b01;
  end

  assign spi_io_out = lane2 ? sh_q[SH_W-1 -: 2] : {1'b0, sh_q[SH_W-1]};
  assign spi_sclk   = sclk_q;
  assign spi_cs_n   = csn_q;
  assign done       = done_q;
  assign busy       = (ph_q != PH_IDLE);
  assign tx_free    = TXC_W'(TX_DEPTH) - tx_count;
  assign rx_empty   = (rx_count == '0);
endmodule

// File: rtl/sfx_engine_chk.sv
module sfx_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic [1:0] spi_io_oe
);
  assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_cs_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  assert_start_on_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(req_valid && !busy));
  assert_busy_ends_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_at_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_lane_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_io_oe[1] |-> spi_io_oe[0]);
endmodule

bind sfx_engine sfx_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_io_oe(spi_io_oe)
);

// File: tb/sfx_engine_tb.sv
module sfx_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_addr_en, req_write;
  logic [7:0]  req_opcode;
  logic [23:0] req_addr;
  logic [9:0]  req_len;
  logic        busy, done, tx_push, rx_pop, rx_empty;
  logic [7:0]  tx_data, rx_data;
  logic [2:0]  tx_free;
  logic        spi_sclk, spi_cs_n;
  logic [1:0]  spi_io_out, spi_io_oe, spi_io_in;

  always #4 clk = ~clk;

  sfx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_addr(req_addr), .req_addr_en(req_addr_en), .req_write(req_write),
    .req_len(req_len), .busy(busy), .done(done), .tx_push(tx_push),
    .tx_data(tx_data), .tx_free(tx_free), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_empty(rx_empty), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  typedef struct {
    logic [7:0]  opc;
    bit          has_addr;
    logic [23:0] addr;
    bit          dual;
    int          dummy;
    int          mode;   // 0 none, 1 write, 2 read
    int          nbytes;
    int          seed;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cs_falls = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] wdat(input int s, input int k);
    return 8'(s * 29 + k * 13 + 1);
  endfunction
  function automatic logic [7:0] rdat(input int s, input int k);
    return 8'(s * 31 + k * 7 + 5);
  endfunction

  // flash model and scoreboard monitor
  initial begin
    spi_io_in = 2'b00;
    forever begin
      exp_t        e;
      logic [7:0]  v;
      logic [23:0] a;
      int          lanes;
      int          bad_oe;
      @(negedge spi_cs_n);
      cs_falls++;
      if (q.size() == 0) begin
        chk(1'b0, "R11", "unexpected transaction opcode", 0, 0);
      end else begin
        e = q.pop_front();
        lanes = e.dual ? 2 : 1;
        v = '0; bad_oe = 0;
        for (int i = 0; i < 8; i++) begin
          @(posedge spi_sclk); #1;
          v = {v[6:0], spi_io_out[0]};
          if (spi_io_oe != 2'b01) bad_oe++;
        end
        chk(v == e.opc, "R1", "opcode", v, e.opc);
        chk(bad_oe == 0, "R1", "opcode lane enables", bad_oe, 0);
        if (e.has_addr) begin
          a = '0;
          for (int i = 0; i < 24 / lanes; i++) begin
            @(posedge spi_sclk); #1;
            if (e.dual) a = {a[21:0], spi_io_out[1:0]};
            else        a = {a[22:0], spi_io_out[0]};
          end
          chk(a == e.addr, e.tag, "address (R2)", a, e.addr);
        end
        bad_oe = 0;
        for (int i = 0; i < e.dummy; i++) begin
          @(posedge spi_sclk); #1;
          if (spi_io_oe != 2'b00) bad_oe++;
        end
        chk(bad_oe == 0, e.tag, "dummy cycles drive bus", bad_oe, 0);
        for (int k = 0; k < e.nbytes; k++) begin
          if (e.mode == 1) begin
            v = '0; bad_oe = 0;
            for (int b = 0; b < 8 / lanes; b++) begin
              @(posedge spi_sclk); #1;
              if (e.dual) v = {v[5:0], spi_io_out[1:0]};
              else        v = {v[6:0], spi_io_out[0]};
              if (spi_io_oe != (e.dual ? 2'b11 : 2'b01)) bad_oe++;
            end
            chk(v == wdat(e.seed, k), e.tag, "write byte (R9)", v, wdat(e.seed, k));
            chk(bad_oe == 0, e.tag, "write lane enables", bad_oe, 0);
          end else begin
            v = rdat(e.seed, k);
            for (int b = 0; b < 8 / lanes; b++) begin
              @(negedge spi_sclk); #1;
              if (e.dual) spi_io_in = v[7:6];
              else        spi_io_in = {v[7], 1'b0};
              v = e.dual ? (v << 2) : (v << 1);
              @(posedge spi_sclk);
            end
          end
        end
        @(posedge spi_cs_n or posedge spi_sclk); #1;
        chk(spi_cs_n == 1'b1, e.tag, "extra SCLK edge before release (R3)", spi_cs_n, 1);
      end
    end
  end

  task automatic run(input logic [7:0] opc, input logic [23:0] addr, input bit aen,
                     input bit wr, input int len, input bit faddr, input bit dual,
                     input int dummy, input bit drop, input string tag, input int seed,
                     input int feed_gap, input int pop_delay, input int ignore_at);
    exp_t e;
    int   nb = (len > 512) ? 512 : len;
    int   pushed = 0, popped = 0, cycles = 0, gap = 0, falls0;
    bit   got_done = 0;
    e.opc = opc; e.has_addr = aen || faddr; e.addr = addr; e.dual = dual;
    e.dummy = dummy; e.mode = (nb == 0) ? 0 : (wr ? 1 : 2); e.nbytes = nb;
    e.seed = seed; e.tag = tag;
    falls0 = cs_falls;
    if (!drop) q.push_back(e);
    req_opcode = opc; req_addr = addr; req_addr_en = aen; req_write = wr;
    req_len = 10'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!drop) chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
    forever begin
      tx_push = 1'b0; rx_pop = 1'b0; req_valid = 1'b0;
      if (done) got_done = 1;
      if (got_done && (wr || popped >= nb)) break;
      if (cycles > 60000) begin
        chk(1'b0, tag, "transaction timeout", cycles, 0);
        break;
      end
      if (cycles == ignore_at) begin
        req_valid = 1'b1; req_opcode = 8'h9F; req_len = 10'd3; req_addr_en = 1'b0;
        req_write = 1'b0;
      end
      if (wr && pushed < nb && tx_free != 0) begin
        if (gap == 0) begin
          tx_push = 1'b1; tx_data = wdat(seed, pushed); pushed++; gap = feed_gap;
        end else gap--;
      end
      if (!wr && !rx_empty && cycles >= pop_delay) begin
        chk(rx_data == rdat(seed, popped), tag, "read byte (R10)", rx_data, rdat(seed, popped));
        rx_pop = 1'b1; popped++;
      end
      @(negedge clk);
      cycles++;
    end
    if (drop) begin
      chk(cycles <= 1, "R8", "dropped request done latency", cycles, 1);
      chk(cs_falls == falls0, "R8", "chip select activity on drop", cs_falls - falls0, 0);
    end else begin
      chk(busy == 1'b0, "R11", "busy after done", busy, 0);
      if (!wr) chk(popped == nb, tag, "byte count (R4)", popped, nb);
    end
    repeat (2) @(negedge clk);
    chk(q.size() == 0, tag, "expected transaction not seen", q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R11", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_opcode = '0; req_addr = '0; req_addr_en = 1'b0;
    req_write = 1'b0; req_len = '0; tx_push = 1'b0; tx_data = '0; rx_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(spi_cs_n == 1'b1, "R13", "cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R13", "sclk", spi_sclk, 0);
    chk(busy == 1'b0 && done == 1'b0, "R13", "busy/done", {busy, done}, 0);
    chk(spi_io_oe == 2'b00, "R13", "io_oe", spi_io_oe, 0);
    chk(tx_free == 3'd4 && rx_empty, "R13", "fifo levels", {tx_free, rx_empty}, 9);

    // opcode-only status-style read, one byte
    run(8'h05, 24'h0, 0, 0, 1, 0, 0, 0, 0, "R10", 1, 0, 0, -1);
    // command only, no address (R3)
    run(8'h06, 24'h0, 0, 0, 0, 0, 0, 0, 0, "R3", 2, 0, 0, -1);
    // addressed, zero length (R2, R3)
    run(8'h20, 24'h123456, 1, 0, 0, 0, 0, 0, 0, "R3", 3, 0, 0, -1);
    // plain addressed read (R2)
    run(8'h03, 24'hABCDEF, 1, 0, 5, 0, 0, 0, 0, "R2", 4, 0, 0, -1);
    // plain write fed slowly: SCLK must pause (R9)
    run(8'h42, 24'h00F00F, 1, 1, 6, 0, 0, 0, 0, "R9", 5, 40, 0, -1);
    // fast read, address flag clear but forced (R5)
    run(8'hBB, 24'h5A5A5A, 0, 0, 7, 1, 1, 3, 0, "R5", 6, 0, 0, -1);
    // discovery read (R6)
    run(8'h5A, 24'h000010, 0, 0, 4, 1, 0, 8, 0, "R6", 7, 0, 0, -1);
    // page program (R7)
    run(8'hA2, 24'hC0FFEE, 0, 1, 9, 1, 1, 0, 0, "R7", 8, 0, 0, -1);
    // zero-length fast read and page program are dropped (R8)
    run(8'hBB, 24'h1, 0, 0, 0, 1, 1, 3, 1, "R8", 9, 0, 0, -1);
    run(8'hA2, 24'h1, 0, 1, 0, 1, 1, 0, 1, "R8", 10, 0, 0, -1);
    // read with slow draining: RX full pause (R10)
    run(8'h03, 24'h000100, 1, 0, 10, 0, 0, 0, 0, "R10", 11, 0, 300, -1);
    // request while busy is ignored (R11)
    run(8'h03, 24'h777777, 1, 0, 3, 0, 0, 0, 0, "R11", 12, 0, 0, 20);
    // length cap: 600 requested, 512 moved (R4)
    run(8'hBB, 24'h200000, 0, 0, 600, 1, 1, 3, 0, "R4", 13, 0, 0, -1);
    // exactly 512 bytes programmed (R4)
    run(8'hA2, 24'h300000, 0, 1, 512, 1, 1, 0, 0, "R4", 14, 0, 0, -1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule